// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets clocked logic use an external asynchronous static RAM of 512K bytes. A client presents an address, write data and a read/write select with a valid/ready handshake. The controller then drives the memory's active-low chip-select, write-strobe and output-enable pins and its 19-bit address bus. For a write it drives the data bus. For a read it captures the returned byte. It ends every access with a one-cycle completion pulse on the client side.

The memory's nanosecond limits are parameters: access time, output-enable delay, strobe width, data and address setup, release-to-high-Z time, and minimum cycle time. A clock-period parameter is also given. At elaboration each limit becomes a whole number of clock cycles, rounded up, with a minimum of one. Writes use a strobe-controlled pulse with output enable held high, so the memory never drives the bus while the controller does. After every read the controller waits for the memory's drivers to release the bus before it accepts new work.

The data bus is split into an output word, an output-enable and an input word, so the pad ring builds the tri-state buffer. Between requests all three control pins stay high and the memory sits in its deselected low-power state.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, and whenever the controller is idle, mem_ce_n, mem_we_n and mem_oe_n are all 1, mem_dq_oe is 0, rsp_done is 0 and req_ready is 1.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready then stays 0 until the access is complete. req_valid asserted while req_ready is 0 is ignored and starts no memory cycle.
- R3: A write (req_wr = 1) holds mem_we_n low for ceil(max(strobe width, data setup, address setup)/period) cycles: 8 cycles with default parameters. During the pulse mem_ce_n is 0, mem_oe_n is 1 and mem_dq_oe is 1. mem_addr is stable for the whole pulse, and mem_dq_oe stays 1 up to and including the rising edge of mem_we_n.
- R4: A read (req_wr = 0) holds mem_oe_n low, with mem_ce_n 0 and mem_we_n 1, for ceil(max(address access, select access, output-enable access)/period) cycles: 9 cycles with default parameters. At the clock edge that ends this window the bus byte is captured into rsp_rdata.
- R5: After a read, at least ceil(high-Z time/period) cycles pass after mem_oe_n rises before req_ready returns: exactly 4 with default parameters. mem_dq_oe is never 1 before mem_oe_n has been high for that many cycles.
- R6: rsp_done is a single-cycle pulse, given once per request. For a read it is high in the first cycle in which rsp_rdata holds the new byte, and req_ready is 0 while rsp_done is 1.
- R7: From acceptance to the next req_ready, an access takes at least ceil(minimum cycle time/period) cycles.
- R8: mem_dq_oe is never 1 while mem_oe_n is 0, so the bus is never driven from both ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte captured by the last read |
| mem_addr | output | 19 | Memory address bus |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_o | output | 8 | Byte the controller places on the data bus |
| mem_dq_oe | output | 1 | Controller drives the data bus when 1 |
| mem_dq_i | input | 8 | Byte read from the data bus |

## Verification
The bench builds the controller with its default parameters: an 8 ns period and a memory with 70 ns access and cycle time. This turns every limit into a multi-cycle window: a 9-cycle read window, an 8-cycle write strobe and a 4-cycle release wait. An off-by-one in any counter therefore shows up directly in the measured pulse lengths. The memory model in the bench returns the inverted byte until the access and output-enable times have passed since the last address, select or enable change. A read window that is too short is therefore caught as wrong data. The model also counts any moment when both sides drive the bus.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RD_ACCESS,
        ST_RD_TURN,
        ST_WR_PULSE,
        ST_WR_HOLD
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } pin_ctl_t;

    // Whole cycles needed to cover a limit in ns, never fewer than one.
    function automatic int unsigned ns_to_cycles(input int unsigned lim_ns,
                                                 input int unsigned per_ns);
        int unsigned c;
        c = (lim_ns + per_ns - 1) / per_ns;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        return max2(max2(a, b), c);
    endfunction

    // Memory pin levels that belong to each sequencer state.
    function automatic pin_ctl_t pins_for(input seq_state_e st);
        pin_ctl_t p;
        p = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
        case (st)
            ST_SETUP:     p.ce_n = 1'b0;
            ST_RD_ACCESS: begin
                p.ce_n = 1'b0;
                p.oe_n = 1'b0;
            end
            ST_WR_PULSE:  begin
                p.ce_n  = 1'b0;
                p.we_n  = 1'b0;
                p.dq_oe = 1'b1;
            end
            ST_WR_HOLD:   begin
                p.ce_n  = 1'b0;
                p.dq_oe = 1'b1;
            end
            default:      ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
`timescale 1ns/1ps
module sram_ctrl_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/1ps
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned RD_CYC = 9,
    parameter int unsigned HZ_CYC = 4,
    parameter int unsigned WP_CYC = 8,
    parameter int unsigned WH_CYC = 1,
    parameter int unsigned RC_CYC = 9,
    parameter int unsigned WC_CYC = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_wr,
    input  logic             op_wr,
    input  logic             ph_zero,
    input  logic             cyc_zero,
    output seq_state_e       state,
    output logic             accept,
    output logic             capture,
    output logic             done_set,
    output logic             ph_load,
    output logic [CNT_W-1:0] ph_val,
    output logic             cyc_load,
    output logic [CNT_W-1:0] cyc_val
);
    localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] HZ_LD = CNT_W'(HZ_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] WH_LD = CNT_W'(WH_CYC - 1);
    localparam logic [CNT_W-1:0] RC_LD = CNT_W'(RC_CYC - 1);
    localparam logic [CNT_W-1:0] WC_LD = CNT_W'(WC_CYC - 1);

    seq_state_e nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt      = state;
        accept   = 1'b0;
        capture  = 1'b0;
        done_set = 1'b0;
        ph_load  = 1'b0;
        ph_val   = '0;
        cyc_load = 1'b0;
        cyc_val  = '0;
        case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    cyc_load = 1'b1;
                    cyc_val  = req_wr ? WC_LD : RC_LD;
                    nxt      = ST_SETUP;
                end
            end
            ST_SETUP: begin
                ph_load = 1'b1;
                ph_val  = op_wr ? WP_LD : RD_LD;
                nxt     = op_wr ? ST_WR_PULSE : ST_RD_ACCESS;
            end
            ST_RD_ACCESS: begin
                if (ph_zero) begin
                    capture  = 1'b1;
                    done_set = 1'b1;
                    ph_load  = 1'b1;
                    ph_val   = HZ_LD;
                    nxt      = ST_RD_TURN;
                end
            end
            ST_RD_TURN: begin
                if (ph_zero && cyc_zero) nxt = ST_IDLE;
            end
            ST_WR_PULSE: begin
                if (ph_zero) begin
                    done_set = 1'b1;
                    ph_load  = 1'b1;
                    ph_val   = WH_LD;
                    nxt      = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: begin
                if (ph_zero && cyc_zero) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/sram_ctrl_datapath.sv
`timescale 1ns/1ps
module sram_ctrl_datapath
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state,
    input  logic              accept,
    input  logic              capture,
    input  logic              done_set,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              op_wr,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output pin_ctl_t          pins
);
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    req_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (accept) begin
            held <= '{wr: req_wr, addr: req_addr, wdata: req_wdata};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_rdata <= '0;
            rsp_done  <= 1'b0;
        end else begin
            rsp_done <= done_set;
            if (capture) rsp_rdata <= mem_dq_i;
        end
    end

    assign op_wr    = held.wr;
    assign mem_addr = held.addr;
    assign mem_dq_o = held.wdata;
    assign pins     = pins_for(state);
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 19,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 8,
    parameter int unsigned T_AA_NS       = 70,
    parameter int unsigned T_ACE_NS      = 70,
    parameter int unsigned T_DOE_NS      = 35,
    parameter int unsigned T_HZ_NS       = 25,
    parameter int unsigned T_RC_NS       = 70,
    parameter int unsigned T_WC_NS       = 70,
    parameter int unsigned T_PWE_NS      = 50,
    parameter int unsigned T_SD_NS       = 30,
    parameter int unsigned T_AW_NS       = 60,
    parameter int unsigned T_HD_NS       = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int unsigned RD_CYC = max3(ns_to_cycles(T_AA_NS, CLK_PERIOD_NS),
                                          ns_to_cycles(T_ACE_NS, CLK_PERIOD_NS),
                                          ns_to_cycles(T_DOE_NS, CLK_PERIOD_NS));
    localparam int unsigned HZ_CYC = ns_to_cycles(T_HZ_NS, CLK_PERIOD_NS);
    localparam int unsigned WP_CYC = max3(ns_to_cycles(T_PWE_NS, CLK_PERIOD_NS),
                                          ns_to_cycles(T_SD_NS, CLK_PERIOD_NS),
                                          ns_to_cycles(T_AW_NS, CLK_PERIOD_NS));
    localparam int unsigned WH_CYC = ns_to_cycles(T_HD_NS, CLK_PERIOD_NS);
    localparam int unsigned RC_CYC = ns_to_cycles(T_RC_NS, CLK_PERIOD_NS);
    localparam int unsigned WC_CYC = ns_to_cycles(T_WC_NS, CLK_PERIOD_NS);
    localparam int unsigned MAX_CYC = max3(max3(RD_CYC, HZ_CYC, WP_CYC),
                                           max2(WH_CYC, RC_CYC), WC_CYC);
    localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);

    seq_state_e       state;
    pin_ctl_t         pins;
    logic             accept, capture, done_set, op_wr;
    logic             ph_load, ph_zero, cyc_load, cyc_zero;
    logic [CNT_W-1:0] ph_val, cyc_val;

    sram_ctrl_seq #(
        .CNT_W (CNT_W),
        .RD_CYC(RD_CYC),
        .HZ_CYC(HZ_CYC),
        .WP_CYC(WP_CYC),
        .WH_CYC(WH_CYC),
        .RC_CYC(RC_CYC),
        .WC_CYC(WC_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_wr   (req_wr),
        .op_wr    (op_wr),
        .ph_zero  (ph_zero),
        .cyc_zero (cyc_zero),
        .state    (state),
        .accept   (accept),
        .capture  (capture),
        .done_set (done_set),
        .ph_load  (ph_load),
        .ph_val   (ph_val),
        .cyc_load (cyc_load),
        .cyc_val  (cyc_val)
    );

    // Phase timer paces each state; cycle timer enforces the minimum cycle time.
    sram_ctrl_timer #(.CNT_W(CNT_W)) u_phase_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (ph_load),
        .load_val(ph_val),
        .zero    (ph_zero)
    );

    sram_ctrl_timer #(.CNT_W(CNT_W)) u_cycle_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (cyc_load),
        .load_val(cyc_val),
        .zero    (cyc_zero)
    );

    sram_ctrl_datapath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_dp (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .accept   (accept),
        .capture  (capture),
        .done_set (done_set),
        .req_wr   (req_wr),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .mem_dq_i (mem_dq_i),
        .op_wr    (op_wr),
        .rsp_done (rsp_done),
        .rsp_rdata(rsp_rdata),
        .mem_addr (mem_addr),
        .mem_dq_o (mem_dq_o),
        .pins     (pins)
    );

    assign req_ready = (state == ST_IDLE);
    assign mem_ce_n  = pins.ce_n;
    assign mem_we_n  = pins.we_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_dq_oe = pins.dq_oe;
endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
module sram_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 19,
    parameter int unsigned CLK_PERIOD_NS = 8,
    parameter int unsigned T_HZ_NS       = 25
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    localparam int unsigned HZ_CYC = ns_to_cycles(T_HZ_NS, CLK_PERIOD_NS);

    // Cycles that output enable has been high before the current cycle, saturating.
    logic [7:0] oe_high_cnt;
    always_ff @(posedge clk) begin
        if (rst)                    oe_high_cnt <= 8'hFF;
        else if (!mem_oe_n)         oe_high_cnt <= 8'h00;
        else if (oe_high_cnt != 8'hFF) oe_high_cnt <= oe_high_cnt + 8'h01;
    end

    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    // R3
    wr_pulse_pins_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

    // R3
    wr_addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

    // R3
    wr_end_drive_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> mem_dq_oe);

    // R4
    rd_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> (!mem_ce_n && mem_we_n));

    // R5
    bus_release_chk: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (oe_high_cnt >= 8'(HZ_CYC)));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R6
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> !req_ready);

    // R8
    no_fight_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe);
endmodule

bind sram_ctrl sram_ctrl_chk #(
    .ADDR_W       (ADDR_W),
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .T_HZ_NS      (T_HZ_NS)
) u_chk (.*);

// File: tb/sram_ctrl_bench.sv
`timescale 1ns/1ps
module sram_ctrl_bench;
    localparam int PER = 8;
    function automatic int cdiv(input int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction
    localparam int EXP_WP = 8;  // max(50,30,60)/8 rounded up
    localparam int EXP_RD = 9;  // max(70,70,35)/8 rounded up
    localparam int EXP_HZ = 4;  // 25/8 rounded up

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_wr = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_done, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  rsp_rdata, mem_dq_o;
    logic [7:0]  mem_dq_i = 8'h00;
    logic [18:0] mem_addr;

    int checks = 0;
    int errors = 0;

    always #(PER/2) clk = ~clk;

    sram_ctrl u_sram_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // ---------------- memory model ----------------
    logic [7:0] store [logic [18:0]];
    realtime t_addr = 0, t_ce = 0, t_oe = 0;
    int fights = 0;
    int undriven_writes = 0;

    function automatic logic [7:0] peek(input logic [18:0] a);
        return store.exists(a) ? store[a] : 8'h00;
    endfunction

    always @(mem_addr)        t_addr = $realtime;
    always @(negedge mem_ce_n) t_ce  = $realtime;
    always @(negedge mem_oe_n) t_oe  = $realtime;

    always @(posedge mem_we_n) begin
        if (!mem_ce_n) begin
            if (!mem_dq_oe) undriven_writes++;
            store[mem_addr] = mem_dq_o;
        end
    end

    initial begin
        realtime ready_at;
        #0.5;
        forever begin
            if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
                if (mem_dq_oe) fights++;
                ready_at = t_addr + 70;
                if (t_ce + 70 > ready_at) ready_at = t_ce + 70;
                if (t_oe + 35 > ready_at) ready_at = t_oe + 35;
                mem_dq_i = ($realtime >= ready_at) ? peek(mem_addr) : ~peek(mem_addr);
            end else begin
                mem_dq_i = 8'h00;
            end
            #1;
        end
    end

    // ---------------- pin monitor (samples 2 ns after each rising edge) ----------------
    int cyc = 0;
    int we_run = 0, oe_run = 0, last_we_len = 0, last_oe_len = 0;
    int oe_rise_cyc = 0, ready_rise_cyc = 0, accept_cyc = 0;
    int we_lows = 0;
    logic prev_ready = 1'b1, prev_oe = 1'b1;

    always @(posedge clk) begin
        #2;
        cyc++;
        if (!mem_we_n) begin
            we_run++;
            we_lows++;
        end else if (we_run != 0) begin
            last_we_len = we_run;
            we_run = 0;
        end
        if (!mem_oe_n) oe_run++;
        else if (oe_run != 0) begin
            last_oe_len = oe_run;
            oe_run = 0;
        end
        if (mem_oe_n && !prev_oe)     oe_rise_cyc = cyc;
        if (req_ready && !prev_ready) ready_rise_cyc = cyc;
        prev_oe    = mem_oe_n;
        prev_ready = req_ready;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- request helpers ----------------
    task automatic start_req(input logic wr, input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_wr    = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        accept_cyc = cyc;
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!rsp_done) @(negedge clk);
    endtask

    task automatic wait_ready();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic do_write(input logic [18:0] a, input logic [7:0] d);
        start_req(1'b1, a, d);
        wait_done();
        @(negedge clk);
        check("R6", "write done width", int'(rsp_done), 0);
        wait_ready();
        check("R3", "write strobe cycles", last_we_len, EXP_WP);
        check("R7", "write cycle not too short", int'(ready_rise_cyc - accept_cyc + 1 >= cdiv(70)), 1);
        check("R3", "stored byte", int'(peek(a)), int'(d));
    endtask

    task automatic do_read(input logic [18:0] a, input logic [7:0] exp);
        start_req(1'b0, a, 8'h00);
        check("R2", "ready low while busy", int'(req_ready), 0);
        wait_done();
        check("R4", "read data", int'(rsp_rdata), int'(exp));
        check("R6", "ready low with done", int'(req_ready), 0);
        @(negedge clk);
        check("R6", "read done width", int'(rsp_done), 0);
        wait_ready();
        check("R4", "output enable cycles", last_oe_len, EXP_RD);
        check("R5", "release wait cycles", ready_rise_cyc - oe_rise_cyc, EXP_HZ);
        check("R7", "read cycle not too short", int'(ready_rise_cyc - accept_cyc + 1 >= cdiv(70)), 1);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "ready after reset", int'(req_ready), 1);
        check("R1", "ce_n after reset", int'(mem_ce_n), 1);
        check("R1", "we_n after reset", int'(mem_we_n), 1);
        check("R1", "oe_n after reset", int'(mem_oe_n), 1);
        check("R1", "dq_oe after reset", int'(mem_dq_oe), 0);
        check("R1", "done after reset", int'(rsp_done), 0);
    endtask

    task automatic t_write_read_patterns();
        do_write(19'h00000, 8'h00);
        do_write(19'h7FFFF, 8'hFF);
        do_write(19'h2A5A5, 8'h5A);
        do_write(19'h15A5A, 8'hA5);
        do_read(19'h7FFFF, 8'hFF);
        do_read(19'h00000, 8'h00);
        do_read(19'h2A5A5, 8'h5A);
        do_read(19'h15A5A, 8'hA5);
    endtask

    task automatic t_overwrite_turnaround();
        do_write(19'h01234, 8'h11);
        do_read(19'h01234, 8'h11);
        do_write(19'h01234, 8'hEE);   // write right after a read
        do_read(19'h01234, 8'hEE);
        do_read(19'h7FFFF, 8'hFF);    // back-to-back reads
    endtask

    task automatic t_ignored_request();
        int lows_before;
        do_write(19'h00ABC, 8'h3C);
        do_write(19'h00DEF, 8'hC3);
        lows_before = we_lows;
        start_req(1'b0, 19'h00ABC, 8'h00);
        for (int i = 0; i < 3; i++) begin
            req_valid = 1'b1;
            req_wr    = 1'b1;
            req_addr  = 19'h00DEF;
            req_wdata = 8'h77;
            @(negedge clk);
            check("R2", "ready held low", int'(req_ready), 0);
        end
        req_valid = 1'b0;
        wait_done();
        check("R2", "read data under stray request", int'(rsp_rdata), 8'h3C);
        wait_ready();
        @(negedge clk);
        check("R2", "no strobe from stray request", we_lows - lows_before, 0);
        check("R2", "stray target untouched", int'(peek(19'h00DEF)), 8'hC3);
        do_read(19'h00DEF, 8'hC3);
    endtask

    task automatic t_idle_quiet();
        repeat (5) @(negedge clk);
        check("R1", "idle ce_n", int'(mem_ce_n), 1);
        check("R1", "idle oe_n", int'(mem_oe_n), 1);
        check("R1", "idle we_n", int'(mem_we_n), 1);
        check("R1", "idle dq_oe", int'(mem_dq_oe), 0);
        check("R8", "bus fights", fights, 0);
        check("R3", "writes ended without data", undriven_writes, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_write_read_patterns();
                t_overwrite_turnaround();
                t_ignored_request();
                t_idle_quiet();
            end
            begin
                #1000000;
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule